// File: doc/BRIEF.md
# Sprite XOR Framebuffer Draw Engine

This block carries out the sprite-draw operation of a small 8-bit interpreter-style processor. The picture is a 64 by 32 one-bit framebuffer held inside the block. When the processor raises a start pulse, the block captures four things: the draw opcode, the values already read from the two coordinate registers, and the index pointer. It then reads the sprite one byte per row from a synchronous memory. Each sprite bit is combined into the picture by exclusive-OR.

When the sprite is finished, the block raises a one-cycle done pulse. With it comes a flag that the processor writes into its flag register. The flag reports whether any lit pixel was switched off. A separate port lets a display scanner read single pixels at any time. A clear input blanks the whole picture while the engine is idle.

Each sprite row costs a fixed ten cycles: one to issue the read, one to capture the byte, and eight to update one pixel each. A draw of n rows therefore ends with done in the cycle that follows 10·n clock edges after start.

Top module: `sprite_xor_engine`

## Requirements
- R1: While reset is held, and after it is released with no other stimulus, busy, done, vf_flag and mem_rd are 0, and every pixel reads back as 0.
- R2: The row count n is opcode bits 3:0. Opcode bits 15:4 have no effect on the draw.
- R3: Row r (0 ≤ r < n) is fetched with a one-cycle mem_rd pulse at address (index_ptr + r) modulo 4096. The pulse is high in the cycle following 1+10·r clock edges after start, counting the start edge as edge 0. The byte is taken from mem_data in the cycle after that pulse.
- R4: Bit 7 of a sprite byte lands at column X, bit 6 at column X+1, and so on down to bit 0 at column X+7. Row r is drawn at line Y+r. Pixel (x, y) lives at linear index x + 64·y.
- R5: A sprite bit of 1 inverts the stored pixel. A sprite bit of 0 leaves the stored pixel unchanged.
- R6: Coordinates wrap for each pixel: the column is taken modulo 64 and the line modulo 32. This applies to x_val and y_val values above the screen size as well.
- R7: vf_flag is 1 during the done pulse if at least one pixel that was 1 became 0 during the draw, and 0 otherwise. At all other times vf_flag is 0.
- R8: A draw with n = 0 issues no memory reads. It gives done in the cycle right after start, with vf_flag at 0.
- R9: busy is high from the cycle after start up to and including the done cycle. done is high for exactly one cycle. busy is low in the cycle after done.
- R10: A start pulse that arrives while busy is high is ignored. Read timing, read addresses and the resulting picture all stay as they would be without that pulse.
- R11: A clear pulse while idle, without start in the same cycle, sets all 2048 pixels to 0 at the next edge. A clear while busy is ignored.
- R12: disp_pix gives the stored pixel at (disp_x, disp_y) one cycle after those coordinates are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a draw when idle |
| opcode | input | 16 | Draw opcode; bits 3:0 give the row count |
| x_val | input | 8 | Column coordinate value |
| y_val | input | 8 | Line coordinate value |
| index_ptr | input | 16 | Sprite base address; low 12 bits are used |
| clear | input | 1 | Blank the picture while idle |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 12 | Memory read address |
| mem_data | input | 8 | Read data, valid one cycle after mem_rd |
| busy | output | 1 | Draw in progress |
| done | output | 1 | One-cycle end-of-draw pulse |
| vf_flag | output | 1 | Collision flag, valid with done |
| disp_x | input | 6 | Display read column |
| disp_y | input | 5 | Display read line |
| disp_pix | output | 1 | Display read pixel, one cycle latency |

## Verification
The assertions assume that rst_n is driven low at time zero and that start and clear come from logic clocked by clk. They also assume the memory returns its byte exactly one cycle after a read request. The bench changes inputs only on the falling edge. Its memory model answers every mem_rd on the next rising edge. On cycles with no request it drives a distinct filler byte, so sampling at the wrong time shows up. The bench sends start and clear during a draw on purpose, because the block must ignore them, and never drives inputs outside their declared widths.

// File: rtl/sxe_pkg.sv
package sxe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_CAPT  = 3'd2,
    ST_PIX   = 3'd3,
    ST_DONE  = 3'd4
  } sxe_state_e;
endpackage

// File: rtl/sxe_fbuf.sv
module sxe_fbuf #(
  parameter int CL = 6,
  parameter int RL = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_en,
  input  logic          tgl_en,
  input  logic [IW-1:0] tgl_idx,
  input  logic [IW-1:0] look_idx,
  output logic          look_pix,
  input  logic [IW-1:0] disp_idx,
  output logic          disp_pix
);
  localparam int IW   = CL + RL;
  localparam int NPIX = 1 << IW;

  logic [NPIX-1:0] pix_q, pix_d, tgl_mask;
  logic            disp_d, disp_q;

  for (genvar g = 0; g < NPIX; g++) begin : g_mask
    assign tgl_mask[g] = tgl_en && (tgl_idx == IW'(g));
  end

  always_comb begin
    if (clr_en) pix_d = '0;
    else        pix_d = pix_q ^ tgl_mask;
    disp_d   = pix_q[disp_idx];
    look_pix = pix_q[look_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= '0;
      disp_q <= 1'b0;
    end else begin
      if (clr_en || tgl_en) pix_q <= pix_d;
      disp_q <= disp_d;
    end
  end

  assign disp_pix = disp_q;

  // R11
  clr_vs_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgl_en |-> !clr_en);

  // R5
  tgl_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgl_en && !clr_en) |=> (pix_q[$past(tgl_idx)] != $past(look_pix) || $past(look_idx) != $past(tgl_idx)));
endmodule

// File: rtl/sxe_ctrl.sv
module sxe_ctrl
  import sxe_pkg::*;
#(
  parameter int CL = 6,
  parameter int RL = 5,
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       op_rows,
  input  logic [CL-1:0]    x_lo,
  input  logic [RL-1:0]    y_lo,
  input  logic [AW-1:0]    base_in,
  input  logic             clear_req,
  input  logic [DW-1:0]    mem_data,
  input  logic             look_pix,
  output logic             mem_rd,
  output logic [AW-1:0]    mem_addr,
  output logic [CL+RL-1:0] pix_idx,
  output logic             tgl_en,
  output logic             clr_en,
  output logic             busy,
  output logic             done,
  output logic             flag
);
  localparam int BW = $clog2(DW);
  localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

  sxe_state_e    state_q, state_d;
  logic [3:0]    rows_q, rows_d, row_q, row_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [DW-1:0] byte_q, byte_d;
  logic [CL-1:0] xb_q, xb_d, pix_col;
  logic [RL-1:0] yb_q, yb_d, pix_row;
  logic [AW-1:0] base_q, base_d;
  logic          coll_q, coll_d;
  logic          spr_bit;

  always_comb begin
    spr_bit = byte_q[BIT_LAST - bit_q];
    pix_col = xb_q + CL'(bit_q);
    pix_row = yb_q + RL'(row_q);
    pix_idx = {pix_row, pix_col};
    tgl_en  = (state_q == ST_PIX) && spr_bit;
    mem_rd  = (state_q == ST_ISSUE);
    mem_addr = base_q + AW'(row_q);
    clr_en  = clear_req && (state_q == ST_IDLE) && !start;
    busy    = (state_q != ST_IDLE);
    done    = (state_q == ST_DONE);
    flag    = done && coll_q;
  end

  always_comb begin
    state_d = state_q;
    rows_d  = rows_q;
    row_d   = row_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    xb_d    = xb_q;
    yb_d    = yb_q;
    base_d  = base_q;
    coll_d  = coll_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          rows_d  = op_rows;
          row_d   = '0;
          xb_d    = x_lo;
          yb_d    = y_lo;
          base_d  = base_in;
          coll_d  = 1'b0;
          state_d = (op_rows == 4'd0) ? ST_DONE : ST_ISSUE;
        end
      end
      ST_ISSUE: state_d = ST_CAPT;
      ST_CAPT: begin
        byte_d  = mem_data;
        bit_d   = '0;
        state_d = ST_PIX;
      end
      ST_PIX: begin
        if (spr_bit && look_pix) coll_d = 1'b1;
        bit_d = bit_q + 1'b1;
        if (bit_q == BIT_LAST) begin
          if (row_q == rows_q - 4'd1) begin
            state_d = ST_DONE;
          end else begin
            row_d   = row_q + 4'd1;
            state_d = ST_ISSUE;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rows_q  <= '0;
      row_q   <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
      xb_q    <= '0;
      yb_q    <= '0;
      base_q  <= '0;
      coll_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rows_q  <= rows_d;
      row_q   <= row_d;
      bit_q   <= bit_d;
      if (state_q == ST_CAPT) byte_q <= byte_d;
      xb_q    <= xb_d;
      yb_q    <= yb_d;
      base_q  <= base_d;
      coll_q  <= coll_d;
    end
  end

  // R3
  rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R9
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R7
  coll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !coll_q);

  // R8
  empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rows_q == 4'd0) |-> !flag);

  // R10
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(base_q) && $stable(rows_q));
endmodule

// File: rtl/sprite_xor_engine.sv
module sprite_xor_engine #(
  parameter int COL_BITS  = 6,
  parameter int ROW_BITS  = 5,
  parameter int ADDR_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [15:0]          opcode,
  input  logic [7:0]           x_val,
  input  logic [7:0]           y_val,
  input  logic [15:0]          index_ptr,
  input  logic                 clear,
  output logic                 mem_rd,
  output logic [ADDR_BITS-1:0] mem_addr,
  input  logic [7:0]           mem_data,
  output logic                 busy,
  output logic                 done,
  output logic                 vf_flag,
  input  logic [COL_BITS-1:0]  disp_x,
  input  logic [ROW_BITS-1:0]  disp_y,
  output logic                 disp_pix
);
  localparam int IW = COL_BITS + ROW_BITS;

  logic          rst_s1, rst_s2;
  logic [IW-1:0] pix_idx;
  logic          tgl_en, clr_en, look_pix;
  logic          unused_bits;

  assign unused_bits = ^{opcode[15:4], x_val[7:COL_BITS], y_val[7:ROW_BITS],
                         index_ptr[15:ADDR_BITS]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  sxe_ctrl #(
    .CL(COL_BITS), .RL(ROW_BITS), .AW(ADDR_BITS), .DW(8)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s2),
    .start     (start),
    .op_rows   (opcode[3:0]),
    .x_lo      (x_val[COL_BITS-1:0]),
    .y_lo      (y_val[ROW_BITS-1:0]),
    .base_in   (index_ptr[ADDR_BITS-1:0]),
    .clear_req (clear),
    .mem_data  (mem_data),
    .look_pix  (look_pix),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .pix_idx   (pix_idx),
    .tgl_en    (tgl_en),
    .clr_en    (clr_en),
    .busy      (busy),
    .done      (done),
    .flag      (vf_flag)
  );

  sxe_fbuf #(
    .CL(COL_BITS), .RL(ROW_BITS)
  ) u_fbuf (
    .clk      (clk),
    .rst_n    (rst_s2),
    .clr_en   (clr_en),
    .tgl_en   (tgl_en),
    .tgl_idx  (pix_idx),
    .look_idx (pix_idx),
    .look_pix (look_pix),
    .disp_idx ({disp_y, disp_x}),
    .disp_pix (disp_pix)
  );
endmodule

// File: tb/sprite_xor_engine_bench.sv
module sprite_xor_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, start, clear;
  logic [15:0] opcode, index_ptr;
  logic [7:0]  x_val, y_val, mem_data;
  logic        mem_rd, busy, done, vf_flag, disp_pix;
  logic [11:0] mem_addr;
  logic [5:0]  disp_x;
  logic [4:0]  disp_y;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit fb_m [2048];

  always #(CLK_PERIOD/2) clk = ~clk;

  sprite_xor_engine u_sprite_xor_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .x_val(x_val),
    .y_val(y_val), .index_ptr(index_ptr), .clear(clear), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_data(mem_data), .busy(busy), .done(done),
    .vf_flag(vf_flag), .disp_x(disp_x), .disp_y(disp_y), .disp_pix(disp_pix)
  );

  function automatic logic [7:0] mem_f(input int a);
    int t;
    t = ((a % 4096) * 29 + 7) % 256;
    return 8'(t);
  endfunction

  always @(posedge clk) mem_data <= mem_rd ? mem_f(int'(mem_addr)) : 8'hA5;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_draw(input logic [15:0] op, input int xv, input int yv,
                            input int iv, output bit fl);
    int n;
    n  = int'(op[3:0]);
    fl = 0;
    for (int r = 0; r < n; r++) begin
      logic [7:0] b;
      b = mem_f(iv + r);
      for (int k = 0; k < 8; k++) begin
        if (b[7-k]) begin
          int idx;
          idx = ((xv + k) % 64) + 64 * ((yv + r) % 32);
          if (fb_m[idx]) fl = 1;
          fb_m[idx] = ~fb_m[idx];
        end
      end
    end
  endtask

  task automatic check_idle(input string tag);
    chk(busy == 1'b0, {tag, " busy"}, int'(busy), 0);
    chk(done == 1'b0, {tag, " done"}, int'(done), 0);
    chk(vf_flag == 1'b0, {tag, " vf_flag"}, int'(vf_flag), 0);
    chk(mem_rd == 1'b0, {tag, " mem_rd"}, int'(mem_rd), 0);
  endtask

  task automatic scan(input string tag);
    for (int y = 0; y < 32; y++) begin
      for (int x = 0; x < 64; x++) begin
        disp_x = 6'(x);
        disp_y = 5'(y);
        @(negedge clk);
        chk(disp_pix == fb_m[x + 64*y], tag, int'(disp_pix), int'(fb_m[x + 64*y]));
      end
    end
  endtask

  // R3 R4 R5 R7 R9 R10 R11: per-cycle comparison against the behavioural model
  task automatic draw(input logic [15:0] op, input int xv, input int yv, input int iv,
                      input bit intrude, input string tag);
    int n;
    bit fl;
    n = int'(op[3:0]);
    model_draw(op, xv, yv, iv, fl);
    opcode = op; x_val = 8'(xv); y_val = 8'(yv); index_ptr = 16'(iv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= 10*n + 1; c++) begin
      bit exp_done, exp_rd;
      int exp_addr;
      exp_done = (c == 10*n + 1);
      exp_rd   = (c <= 10*n) && ((c - 1) % 10 == 0);
      exp_addr = (iv + (c - 1) / 10) % 4096;
      chk(busy == 1'b1, {tag, " R9 busy"}, int'(busy), 1);
      chk(done == exp_done, {tag, " R9 done"}, int'(done), int'(exp_done));
      chk(vf_flag == (exp_done && fl), {tag, " R7 vf_flag"}, int'(vf_flag), int'(exp_done && fl));
      chk(mem_rd == exp_rd, {tag, " R3 mem_rd"}, int'(mem_rd), int'(exp_rd));
      if (exp_rd) chk(mem_addr == 12'(exp_addr), {tag, " R3 mem_addr"}, int'(mem_addr), exp_addr);
      if (intrude && c == 2) begin
        start = 1'b1; opcode = 16'hD00F; x_val = 8'd33; y_val = 8'd17; index_ptr = 16'h0777;
      end
      if (intrude && c == 3) start = 1'b0;
      if (intrude && c == 4) clear = 1'b1;
      if (intrude && c == 5) clear = 1'b0;
      @(negedge clk);
    end
    check_idle({tag, " R9 after done"});
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; clear = 1'b0; opcode = '0; x_val = '0; y_val = '0;
    index_ptr = '0; disp_x = '0; disp_y = '0;
    for (int i = 0; i < 2048; i++) fb_m[i] = 0;
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1 after reset");
    scan("R1 pixels zero");

    // R4 R5: first draw on empty picture
    draw(16'hD125, 3, 2, 16'h050, 0, "R4 basic");
    scan("R4 R5 picture");
    // R5 R7: same sprite again erases it and flags
    draw(16'hD125, 3, 2, 16'h050, 0, "R5 erase");
    scan("R5 erased");
    // R2 R6: upper opcode bits differ, wrap at right and bottom edge
    draw(16'h0004, 61, 30, 16'h123, 0, "R2 R6 wrap");
    scan("R6 wrap picture");
    // R6 R10 R11: oversize coordinates, address wrap, start and clear during draw
    draw(16'hDABF, 200, 100, 16'hFF8, 1, "R10 R11 intrude");
    scan("R10 R11 picture kept");
    // R8: zero rows
    draw(16'hD000, 5, 5, 16'h200, 0, "R8 zero rows");
    scan("R8 picture unchanged");
    // R7: overlap with earlier wrapped sprite
    draw(16'h3FF3, 62, 31, 16'h123, 0, "R7 overlap");
    scan("R7 picture");
    // R11: clear while idle
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    for (int i = 0; i < 2048; i++) fb_m[i] = 0;
    check_idle("R11 clear idle");
    scan("R11 R12 cleared");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule